// File: doc/BRIEF.md
# Presettable Down Counter with Terminal Flag

This block is a binary down counter, eight bits wide by default. All of its controls are active low. A clear input forces the count to all ones at once, without waiting for a clock. A second input copies a parallel preset word into the counter at once, also without a clock. A third input loads the preset word on the next rising clock edge. A count-enable input lets the counter step down by one on each rising edge and, when it is inactive, holds the count.

An active-low zero flag is low whenever the count is zero and the count enable is asserted. The flag is combinational, so it follows a change on the enable within the same cycle. When the count is zero and counting is enabled, the next edge wraps the count to all ones. A free-running pass through every value therefore takes 256 clocks.

Counters can be chained. In synchronous chaining every stage shares one clock, and each stage's zero flag drives the count enable of the next stage. In ripple chaining the zero flag of the lower stage is the clock of the upper stage. The upper stage then steps on the rising edge of that flag, which happens when the lower stage wraps.

Top module: `preset_down_counter`

## Requirements
- R1: With every load and clear input inactive (high) and `cnt_en_n` low, each rising clock edge lowers `count` by one.
- R2: With every load and clear input inactive and `cnt_en_n` high, `count` keeps its value across clock edges.
- R3: With `sload_n` low, the next rising clock edge copies `preset` into `count`, whatever the level of `cnt_en_n`.
- R4: Driving `aload_n` low places `preset` on `count` at once, without any clock edge, whatever the levels of `sload_n`, `cnt_en_n` and `clk`. `preset[W-1]` is the most significant bit.
- R5: Driving `rst_max_n` low forces `count` to all ones (255 for W=8) at once, without any clock edge.
- R6: The inputs are ranked `rst_max_n`, then `aload_n`, then `sload_n`, then `cnt_en_n`. When more than one is active, only the highest-ranked one acts.
- R7: `zero_n` is low exactly when `count` is zero and `cnt_en_n` is low. It follows `cnt_en_n` combinationally within the cycle.
- R8: With `count` at zero and only `cnt_en_n` active, the next edge gives all ones, so an undisturbed counting cycle lasts 256 clocks.
- R9: Two instances on one clock, with the lower stage's `zero_n` driving the upper stage's `cnt_en_n`, count down together as one 16-bit value.
- R10: Two instances where the lower stage's `zero_n` clocks the upper stage, and the upper stage's `cnt_en_n` is held low, count down together as one 16-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; acts on the rising edge |
| rst_max_n | input | 1 | Asynchronous clear to all ones, active low |
| aload_n | input | 1 | Asynchronous parallel load of `preset`, active low |
| sload_n | input | 1 | Synchronous parallel load of `preset`, active low |
| cnt_en_n | input | 1 | Count enable, active low; also gates `zero_n` |
| preset | input | W | Parallel load word, MSB at bit W-1 |
| zero_n | output | 1 | Active-low flag: count is zero while enabled |
| count | output | W | Current count value |

## Verification
The hardest situations to reach from the ports are events that take place between clock edges. One is an asynchronous load or clear that changes the count in the middle of a period. The other is the upper stage of a ripple chain, whose only clock is the rising edge of the lower stage's zero flag. The stimulus drives the asynchronous inputs a fraction of a period after a falling edge and samples the count before the next rising edge. The ripple pair is preset asynchronously, then counted across the lower stage's wrap, so that the zero flag rises and steps the upper stage. A full 256-clock pass from zero confirms the wrap period.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Clock-edge action chosen from the synchronous controls.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_DEC   = 2'd1,
    ACT_SLOAD = 2'd2
  } act_e;
endpackage

// File: rtl/pdc_decode.sv
module pdc_decode (
  input  logic           sload_n,
  input  logic           cnt_en_n,
  output pdc_pkg::act_e  act
);
  import pdc_pkg::*;

  // Synchronous load outranks the count enable.
  function automatic act_e pick_action(input logic ld_n, input logic en_n);
    if (!ld_n)      return ACT_SLOAD;
    else if (!en_n) return ACT_DEC;
    else            return ACT_HOLD;
  endfunction

  assign act = pick_action(sload_n, cnt_en_n);
endmodule

// File: rtl/pdc_core.sv
module pdc_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_max_n,
  input  logic           aload_n,
  input  logic [W-1:0]   preset,
  input  pdc_pkg::act_e  act,
  output logic [W-1:0]   count
);
  import pdc_pkg::*;

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  // Next value at a clock edge; the decrement wraps from zero to all ones.
  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic [W-1:0] ld,
                                        input act_e         a);
    case (a)
      ACT_SLOAD: return ld;
      ACT_DEC:   return cur - ONE;
      default:   return cur;
    endcase
  endfunction

  logic [W-1:0] count_q;
  logic         clean_q;   // high when no async event since the last edge

  // Clear outranks the asynchronous load; both outrank the clock.
  always_ff @(posedge clk or negedge rst_max_n or negedge aload_n) begin
    if (!rst_max_n)    count_q <= ALL_ONES;
    else if (!aload_n) count_q <= preset;
    else               count_q <= step(count_q, preset, act);
  end

  always_ff @(posedge clk or negedge rst_max_n or negedge aload_n) begin
    if (!rst_max_n || !aload_n) clean_q <= 1'b0;
    else                        clean_q <= 1'b1;
  end

  assign count = count_q;

  // R1: enabled counting steps down by one
  a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_max_n)
    (aload_n && act == ACT_DEC && count_q != '0) |=>
      (!clean_q || count_q == $past(count_q) - ONE));

  // R8: zero wraps to all ones
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_max_n)
    (aload_n && act == ACT_DEC && count_q == '0) |=> (!clean_q || &count_q));

  // R2: disabled counting holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_max_n)
    (aload_n && act == ACT_HOLD) |=> (!clean_q || $stable(count_q)));

  // R3: synchronous load takes the preset word
  a_r3_sync_load: assert property (@(posedge clk) disable iff (!rst_max_n)
    (aload_n && act == ACT_SLOAD) |=> (!clean_q || count_q == $past(preset)));

  // R4: while the async load is held, the count shows the preset word
  a_r4_async_load: assert property (@(posedge clk) disable iff (!rst_max_n)
    (!aload_n && $stable(preset)) |-> (count_q == preset));

  // R5 R6: clear holds all ones regardless of other inputs
  a_r5_clear_max: assert property (@(posedge clk)
    (!rst_max_n && !$isunknown(rst_max_n)) |-> (count_q == ALL_ONES));
endmodule

// File: rtl/pdc_term.sv
module pdc_term #(
  parameter int W = 8
) (
  input  logic [W-1:0] count,
  input  logic         cnt_en_n,
  output logic         zero_n
);
  function automatic logic terminal(input logic [W-1:0] c, input logic en_n);
    return (c == '0) && !en_n;
  endfunction

  assign zero_n = !terminal(count, cnt_en_n);
endmodule

// File: rtl/preset_down_counter.sv
module preset_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_max_n,
  input  logic         aload_n,
  input  logic         sload_n,
  input  logic         cnt_en_n,
  input  logic [W-1:0] preset,
  output logic         zero_n,
  output logic [W-1:0] count
);
  pdc_pkg::act_e  edge_act;
  logic [W-1:0]   count_w;
  logic           at_zero;

  pdc_decode u_decode (
    .sload_n  (sload_n),
    .cnt_en_n (cnt_en_n),
    .act      (edge_act)
  );

  pdc_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_max_n (rst_max_n),
    .aload_n   (aload_n),
    .preset    (preset),
    .act       (edge_act),
    .count     (count_w)
  );

  pdc_term #(.W(W)) u_term (
    .count    (count_w),
    .cnt_en_n (cnt_en_n),
    .zero_n   (zero_n)
  );

  assign count   = count_w;
  assign at_zero = (count_w == '0);

  // R7: the flag is low only at zero with the count enabled
  a_r7_flag_gated: assert property (@(posedge clk) disable iff (!rst_max_n)
    !zero_n |-> (at_zero && !cnt_en_n));

  // R7: at zero with enable asserted the flag must be low
  a_r7_flag_present: assert property (@(posedge clk) disable iff (!rst_max_n)
    (at_zero && !cnt_en_n) |-> !zero_n);
endmodule

// File: tb/preset_down_counter_bench.sv
`timescale 1ns/1ps
module preset_down_counter_bench;
  localparam int W = 8;
  localparam real HALF = 2.5;   // 200 MHz

  logic clk = 1'b0;
  always #(HALF) clk = ~clk;

  // main instance
  logic         rst_n   = 1'b1;
  logic         al_n    = 1'b1;
  logic         sl_n    = 1'b1;
  logic         en_n    = 1'b1;
  logic [W-1:0] pre     = '0;
  logic         zn;
  logic [W-1:0] cnt;

  preset_down_counter #(.W(W)) u_preset_down_counter (
    .clk(clk), .rst_max_n(rst_n), .aload_n(al_n), .sload_n(sl_n),
    .cnt_en_n(en_n), .preset(pre), .zero_n(zn), .count(cnt));

  // synchronous chain (R9)
  logic         sc_ld_n = 1'b1;
  logic         sc_en_n = 1'b1;
  logic [W-1:0] sc_pre_lo = '0, sc_pre_hi = '0;
  logic         sc_zlo, sc_zhi;
  logic [W-1:0] sc_lo, sc_hi;

  preset_down_counter #(.W(W)) u_sc_lo (
    .clk(clk), .rst_max_n(rst_n), .aload_n(1'b1), .sload_n(sc_ld_n),
    .cnt_en_n(sc_en_n), .preset(sc_pre_lo), .zero_n(sc_zlo), .count(sc_lo));
  preset_down_counter #(.W(W)) u_sc_hi (
    .clk(clk), .rst_max_n(rst_n), .aload_n(1'b1), .sload_n(sc_ld_n),
    .cnt_en_n(sc_zlo), .preset(sc_pre_hi), .zero_n(sc_zhi), .count(sc_hi));

  // ripple chain (R10)
  logic         rc_al_n = 1'b1;
  logic         rc_en_n = 1'b1;
  logic [W-1:0] rc_pre_lo = '0, rc_pre_hi = '0;
  logic         rc_zlo, rc_zhi;
  logic [W-1:0] rc_lo, rc_hi;

  preset_down_counter #(.W(W)) u_rc_lo (
    .clk(clk), .rst_max_n(rst_n), .aload_n(rc_al_n), .sload_n(1'b1),
    .cnt_en_n(rc_en_n), .preset(rc_pre_lo), .zero_n(rc_zlo), .count(rc_lo));
  preset_down_counter #(.W(W)) u_rc_hi (
    .clk(rc_zlo), .rst_max_n(rst_n), .aload_n(rc_al_n), .sload_n(1'b1),
    .cnt_en_n(1'b0), .preset(rc_pre_hi), .zero_n(rc_zhi), .count(rc_hi));

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one rising edge, return just after the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #0.2;
  endtask

  // row = {sload_n, en_n, preset, expected count, expected zero_n}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h03, 8'h03, 1'b1},  // R3 load with count disabled
    {1'b1, 1'b0, 8'h00, 8'h02, 1'b1},  // R1
    {1'b1, 1'b0, 8'h00, 8'h01, 1'b1},  // R1
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R1 R7 flag at zero
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1},  // R2 hold, R7 gated off
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},  // R8 wrap
    {1'b1, 1'b0, 8'h00, 8'hFE, 1'b1},  // R1
    {1'b0, 1'b0, 8'h80, 8'h80, 1'b1},  // R6 sync load beats count
    {1'b1, 1'b1, 8'h00, 8'h80, 1'b1},  // R2
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // R3 R7
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0},  // R6 load of zero beats decrement
    {1'b0, 1'b1, 8'hA5, 8'hA5, 1'b1}   // R3
  };

  initial begin
    #1 rst_n = 1'b0;
    #0.5;
    // R5 reset state without a clock edge
    check("R5 reset count", int'(cnt), 8'hFF);
    check("R7 reset flag", int'(zn), 1);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #0.2;

    // table walk: drive after a falling edge, sample after the next one
    for (int i = 0; i < NV; i++) begin
      sl_n = VEC[i][18];
      en_n = VEC[i][17];
      pre  = VEC[i][16:9];
      tick();
      check($sformatf("R1 R2 R3 R6 R7 R8 row %0d count", i), int'(cnt), int'(VEC[i][8:1]));
      check($sformatf("R7 row %0d flag", i), int'(zn), int'(VEC[i][0]));
    end

    // R7 flag follows enable within the cycle
    sl_n = 1'b0; en_n = 1'b1; pre = 8'h00;
    tick();
    sl_n = 1'b1;
    check("R7 zero disabled", int'(zn), 1);
    en_n = 1'b0; #0.3;
    check("R7 enable falls mid-cycle", int'(zn), 0);
    en_n = 1'b1; #0.3;
    check("R7 enable rises mid-cycle", int'(zn), 1);

    // R8 full 256-clock period from zero
    en_n = 1'b0;
    tick();
    check("R8 first step from zero", int'(cnt), 8'hFF);
    for (int k = 1; k < 256; k++) tick();
    check("R8 back to zero after 256", int'(cnt), 8'h00);
    en_n = 1'b1;

    // R4 async load mid-cycle, beats sync load and count
    pre = 8'h5A; sl_n = 1'b0; en_n = 1'b0;
    #0.3 al_n = 1'b0;
    #0.3;
    check("R4 async load without clock", int'(cnt), 8'h5A);
    al_n = 1'b1; sl_n = 1'b1;
    tick();
    check("R1 count after async load", int'(cnt), 8'h59);
    en_n = 1'b1;
    pre = 8'h80;
    #0.3 al_n = 1'b0;
    #0.3;
    check("R4 MSB is top preset bit", int'(cnt[W-1]), 1);
    al_n = 1'b1;
    tick();
    check("R2 hold after async load", int'(cnt), 8'h80);

    // R5 R6 clear mid-cycle beats async load
    pre = 8'h12;
    #0.3 al_n = 1'b0; rst_n = 1'b0;
    #0.3;
    check("R6 clear beats async load", int'(cnt), 8'hFF);
    al_n = 1'b1; #0.3;
    check("R5 clear held without clock", int'(cnt), 8'hFF);
    rst_n = 1'b1;
    tick();

    // R9 synchronous chain from 0x0102
    sc_pre_lo = 8'h02; sc_pre_hi = 8'h01; sc_ld_n = 1'b0;
    tick();
    check("R9 chain loaded", int'({sc_hi, sc_lo}), 16'h0102);
    sc_ld_n = 1'b1; sc_en_n = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      check($sformatf("R9 chain step %0d", k), int'({sc_hi, sc_lo}), 16'h0102 - k);
    end
    sc_en_n = 1'b1;

    // R10 ripple chain from 0x0301
    rc_pre_lo = 8'h01; rc_pre_hi = 8'h03;
    #0.3 rc_al_n = 1'b0;
    #0.3 rc_al_n = 1'b1;
    check("R10 ripple loaded", int'({rc_hi, rc_lo}), 16'h0301);
    rc_en_n = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      check($sformatf("R10 ripple step %0d", k), int'({rc_hi, rc_lo}), 16'h0301 - k);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule